// File: doc/BRIEF.md
# Translated Access Permission Checker

This block judges one memory access at a time against the translation entry that the lookup logic has already matched. It receives a flag per side (instruction and data) saying whether address translation is on, a hit flag, the page attributes of the matched entry (execute, write-enable, guarded, user-only), the entry's zone index, the full zone protection register and a per-zone write-lock register. From these it reports whether the access is a translation miss or which storage faults apply. The result goes to a downstream priority resolver.

Each fault has its own bit in a fault vector. When several faults apply at once, all of their bits are raised together, and the resolver picks among them. A miss takes precedence inside this block and clears the whole fault vector. All results are registered, so they appear exactly one clock after the access is presented. Reset is synchronous and active high.

Top module: `access_perm_chk`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `res_valid`, `miss` and every bit of `fault` are 0.
- R2: Results appear on the clock edge that follows the one sampling `acc_valid`=1. `res_valid` mirrors `acc_valid` one cycle late. When `acc_valid` was 0, `miss` and `fault` are 0 whatever the other inputs are.
- R3: Access kind encoding: 0 is instruction fetch, 1 is data read, 2 is data write, and 3 is handled as a data read. A fetch uses `xlat_i_on` as its side enable. Reads and writes use `xlat_d_on`.
- R4: When the side enable is 1 and `hit` is 0, `miss` is 1 and all `fault` bits are 0.
- R5: When the side enable is 0, `miss` and all `fault` bits are 0.
- R6: fault[0] (zone deny): set for any access kind on a hit when `user_mode` is 1 and the 2-bit zone field selected by `pg_zone` is 00. Field z sits at `zone_prot[2z+1:2z]`. In supervisor mode, and for any other field value, this bit stays 0.
- R7: fault[1] (no execute): set on a fetch hit when `pg_exec` is 0.
- R8: fault[2] (guarded fetch): set on a fetch hit when `pg_guard` is 1.
- R9: fault[3] (write disabled): set on a write hit when `pg_write` is 0.
- R10: fault[4] (write locked): set on a write hit when `pg_uonly` is 1 or `zone_wrlock[pg_zone]` is 1, in either privilege mode.
- R11: Every applicable fault bit is raised at the same time. Reads never raise bits 1 to 4. Fetches never raise bits 3 and 4. Writes never raise bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| xlat_i_on | input | 1 | Instruction-side translation active |
| xlat_d_on | input | 1 | Data-side translation active |
| hit | input | 1 | Lookup found a valid matching entry |
| pg_exec | input | 1 | Entry execute permission |
| pg_write | input | 1 | Entry write enable |
| pg_guard | input | 1 | Entry guarded marking |
| pg_uonly | input | 1 | Entry user-only (write lock) bit |
| pg_zone | input | ZIW | Entry zone index |
| zone_prot | input | 2*ZONES | Zone protection fields, 2 bits per zone |
| zone_wrlock | input | ZONES | Per-zone write lock bits |
| res_valid | output | 1 | Registered result valid |
| miss | output | 1 | Translation miss |
| fault | output | 5 | Storage fault flags, bit per fault kind |

## Verification
The bench builds the block with four zones, so the zone index is 2 bits and the protection register is 8 bits. With that size it can sweep every combination of access kind, privilege, both side enables, hit, the four page bits and the zone index, under four protection and write-lock patterns. Those patterns place field value 00 and a set lock bit on different zones, so every zone-selected term, every overlap of faults and the masking by a miss are all reached. Idle cycles with fault-provoking inputs cover the no-access case.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  localparam int NFAULT      = 5;
  localparam int F_ZONE      = 0;
  localparam int F_NOEXEC    = 1;
  localparam int F_GUARD     = 2;
  localparam int F_NOWRITE   = 3;
  localparam int F_WRLOCK    = 4;

  typedef logic [NFAULT-1:0] fault_vec_t;

  typedef struct packed {
    logic is_fetch;
    logic is_write;
    logic side_on;
  } acc_dec_t;
endpackage

// File: rtl/apc_zone_sel.sv
module apc_zone_sel #(
  parameter int ZONES = 16,
  parameter int ZIW   = $clog2(ZONES)
) (
  input  logic [ZIW-1:0]     zone_idx,
  input  logic [2*ZONES-1:0] zone_prot,
  input  logic [ZONES-1:0]   zone_wrlock,
  output logic [1:0]         zone_field,
  output logic               zone_lock
);
  logic [1:0] fields [ZONES];

  for (genvar z = 0; z < ZONES; z++) begin : g_unpack
    assign fields[z] = zone_prot[2*z +: 2];
  end

  always_comb begin
    zone_field = fields[zone_idx];
    zone_lock  = zone_wrlock[zone_idx];
  end
endmodule

// File: rtl/apc_kind_dec.sv
module apc_kind_dec
  import apc_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       xlat_i_on,
  input  logic       xlat_d_on,
  output acc_dec_t   dec
);
  always_comb begin
    dec.is_fetch = (acc_kind == KIND_FETCH);
    dec.is_write = (acc_kind == KIND_WRITE);
    dec.side_on  = dec.is_fetch ? xlat_i_on : xlat_d_on;
  end
endmodule

// File: rtl/apc_fault_eval.sv
module apc_fault_eval
  import apc_pkg::*;
(
  input  acc_dec_t   dec,
  input  logic       hit,
  input  logic       user_mode,
  input  logic       pg_exec,
  input  logic       pg_write,
  input  logic       pg_guard,
  input  logic       pg_uonly,
  input  logic [1:0] zone_field,
  input  logic       zone_lock,
  output logic       miss_c,
  output fault_vec_t fault_c
);
  logic checked;

  always_comb begin
    miss_c  = dec.side_on & ~hit;
    checked = dec.side_on & hit;
    fault_c = '0;
    fault_c[F_ZONE]    = checked & user_mode & (zone_field == 2'b00);
    fault_c[F_NOEXEC]  = checked & dec.is_fetch & ~pg_exec;
    fault_c[F_GUARD]   = checked & dec.is_fetch & pg_guard;
    fault_c[F_NOWRITE] = checked & dec.is_write & ~pg_write;
    fault_c[F_WRLOCK]  = checked & dec.is_write & (pg_uonly | zone_lock);
  end
endmodule

// File: rtl/access_perm_chk.sv
module access_perm_chk
  import apc_pkg::*;
#(
  parameter int ZONES = 16,
  parameter int ZIW   = $clog2(ZONES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic [1:0]              acc_kind,
  input  logic                    user_mode,
  input  logic                    xlat_i_on,
  input  logic                    xlat_d_on,
  input  logic                    hit,
  input  logic                    pg_exec,
  input  logic                    pg_write,
  input  logic                    pg_guard,
  input  logic                    pg_uonly,
  input  logic [ZIW-1:0]          pg_zone,
  input  logic [2*ZONES-1:0]      zone_prot,
  input  logic [ZONES-1:0]        zone_wrlock,
  output logic                    res_valid,
  output logic                    miss,
  output logic [NFAULT-1:0]       fault
);
  acc_dec_t   dec;
  logic [1:0] zone_field;
  logic       zone_lock;
  logic       miss_c;
  fault_vec_t fault_c;

  apc_kind_dec u_dec (
    .acc_kind  (acc_kind),
    .xlat_i_on (xlat_i_on),
    .xlat_d_on (xlat_d_on),
    .dec       (dec)
  );

  apc_zone_sel #(.ZONES(ZONES), .ZIW(ZIW)) u_zone (
    .zone_idx    (pg_zone),
    .zone_prot   (zone_prot),
    .zone_wrlock (zone_wrlock),
    .zone_field  (zone_field),
    .zone_lock   (zone_lock)
  );

  apc_fault_eval u_eval (
    .dec        (dec),
    .hit        (hit),
    .user_mode  (user_mode),
    .pg_exec    (pg_exec),
    .pg_write   (pg_write),
    .pg_guard   (pg_guard),
    .pg_uonly   (pg_uonly),
    .zone_field (zone_field),
    .zone_lock  (zone_lock),
    .miss_c     (miss_c),
    .fault_c    (fault_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      miss      <= 1'b0;
      fault     <= '0;
    end else begin
      res_valid <= acc_valid;
      miss      <= acc_valid & miss_c;
      fault     <= acc_valid ? fault_c : '0;
    end
  end
endmodule

// File: rtl/apc_chk.sv
module apc_chk
  import apc_pkg::*;
#(
  parameter int ZONES = 16,
  parameter int ZIW   = $clog2(ZONES)
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic [1:0]         acc_kind,
  input logic               user_mode,
  input logic               xlat_i_on,
  input logic               xlat_d_on,
  input logic               hit,
  input logic               pg_exec,
  input logic               pg_write,
  input logic               pg_guard,
  input logic               pg_uonly,
  input logic [ZIW-1:0]     pg_zone,
  input logic [2*ZONES-1:0] zone_prot,
  input logic [ZONES-1:0]   zone_wrlock,
  input logic               res_valid,
  input logic               miss,
  input logic [NFAULT-1:0]  fault
);
  logic side;
  assign side = (acc_kind == KIND_FETCH) ? xlat_i_on : xlat_d_on;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!res_valid && !miss && fault == '0)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && !miss && fault == '0)); // R2
  AST_MISS_MASKS: assert property (@(posedge clk) disable iff (rst)
    miss |-> (fault == '0)); // R4
  AST_XLAT_OFF: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !side) |=> (!miss && fault == '0)); // R5
  AST_ZONE_DENY: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && side && hit && user_mode && zone_prot[2*pg_zone +: 2] == 2'b00) |=> fault[F_ZONE]); // R6
  AST_SUPV_NO_ZONE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !user_mode) |=> !fault[F_ZONE]); // R6
  AST_NO_EXEC: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_FETCH && xlat_i_on && hit && !pg_exec) |=> fault[F_NOEXEC]); // R7
  AST_WR_LOCK: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == KIND_WRITE && xlat_d_on && hit && (pg_uonly || zone_wrlock[pg_zone])) |=> fault[F_WRLOCK]); // R10
  AST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind != KIND_FETCH && acc_kind != KIND_WRITE) |=> (fault[4:1] == 4'b0)); // R11
endmodule

bind access_perm_chk apc_chk #(.ZONES(ZONES), .ZIW(ZIW)) u_apc_chk (.*);

// File: tb/access_perm_chk_tb.sv
`timescale 1ns/1ps
module access_perm_chk_tb;
  localparam int ZONES = 4;
  localparam int ZIW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [1:0] acc_kind = '0;
  logic user_mode = 1'b0, xlat_i_on = 1'b0, xlat_d_on = 1'b0, hit = 1'b0;
  logic pg_exec = 1'b0, pg_write = 1'b0, pg_guard = 1'b0, pg_uonly = 1'b0;
  logic [ZIW-1:0] pg_zone = '0;
  logic [2*ZONES-1:0] zone_prot = '0;
  logic [ZONES-1:0] zone_wrlock = '0;
  logic res_valid, miss;
  logic [4:0] fault;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  access_perm_chk #(.ZONES(ZONES)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .user_mode(user_mode), .xlat_i_on(xlat_i_on), .xlat_d_on(xlat_d_on),
    .hit(hit), .pg_exec(pg_exec), .pg_write(pg_write), .pg_guard(pg_guard),
    .pg_uonly(pg_uonly), .pg_zone(pg_zone), .zone_prot(zone_prot),
    .zone_wrlock(zone_wrlock), .res_valid(res_valid), .miss(miss), .fault(fault)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    check("R1 res_valid", {7'b0, res_valid}, 8'h0);
    check("R1 miss", {7'b0, miss}, 8'h0);
    check("R1 fault", {3'b0, fault}, 8'h0);
    rst = 1'b0;

    // R2: idle cycles with fault-provoking inputs produce nothing
    acc_valid = 1'b0; acc_kind = 2'd2; user_mode = 1'b1; xlat_i_on = 1'b1;
    xlat_d_on = 1'b1; hit = 1'b0; zone_prot = '0; zone_wrlock = '1;
    @(negedge clk);
    check("R2 idle res_valid", {7'b0, res_valid}, 8'h0);
    check("R2 idle miss", {7'b0, miss}, 8'h0);
    hit = 1'b1;
    @(negedge clk);
    check("R2 idle fault", {3'b0, fault}, 8'h0);

    for (int p = 0; p < 4; p++) begin
      logic [7:0] zp;
      logic [3:0] wl;
      case (p)
        0: begin zp = 8'hE4; wl = 4'b0101; end
        1: begin zp = 8'h1B; wl = 4'b1010; end
        2: begin zp = 8'h00; wl = 4'b0000; end
        default: begin zp = 8'hFF; wl = 4'b1111; end
      endcase
      for (int v = 0; v < 8192; v++) begin
        logic [12:0] b;
        logic [1:0] k, zf;
        logic fetch, wr, side, ok, e_miss;
        logic [4:0] e_f;
        b = v[12:0];
        k = b[1:0];
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; user_mode = b[2];
        xlat_i_on = b[3]; xlat_d_on = b[4]; hit = b[5];
        pg_exec = b[6]; pg_write = b[7]; pg_guard = b[8]; pg_uonly = b[9];
        pg_zone = b[11:10]; zone_prot = zp; zone_wrlock = wl;
        fetch = (k == 2'd0);
        wr = (k == 2'd2);
        side = fetch ? b[3] : b[4];
        ok = side & b[5];
        e_miss = side & ~b[5];
        zf = 2'((zp >> (2 * b[11:10])) & 8'h3);
        e_f[0] = ok & b[2] & (zf == 2'b00);
        e_f[1] = ok & fetch & ~b[6];
        e_f[2] = ok & fetch & b[8];
        e_f[3] = ok & wr & ~b[7];
        e_f[4] = ok & wr & (b[9] | wl[b[11:10]]);
        @(negedge clk);
        check("R2 res_valid", {7'b0, res_valid}, 8'h1);
        if (!side) begin
          check("R5 miss", {7'b0, miss}, 8'h0);
          check("R5 fault", {3'b0, fault}, 8'h0);
        end else begin
          check("R3 R4 miss", {7'b0, miss}, {7'b0, e_miss});
          check("R6 zone deny", {7'b0, fault[0]}, {7'b0, e_f[0]});
          check("R7 no exec", {7'b0, fault[1]}, {7'b0, e_f[1]});
          check("R8 guarded", {7'b0, fault[2]}, {7'b0, e_f[2]});
          check("R9 no write", {7'b0, fault[3]}, {7'b0, e_f[3]});
          check("R10 write lock", {7'b0, fault[4]}, {7'b0, e_f[4]});
          check("R11 all flags", {3'b0, fault}, {3'b0, e_f});
        end
      end
    end
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R2 end idle", {6'b0, res_valid, miss}, 8'h0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule